// File: doc/BRIEF.md
# Compact Branch Resolution Unit

This unit resolves the control-transfer instructions that share a handful of major opcodes in a 64-bit RISC pipeline. Each valid cycle it is given one 32-bit instruction word, the address of that instruction, and the values already read from its two source registers. It reports, one clock later, whether the transfer is taken, the address to fetch next, whether r31 is to be written and with which value, and whether the instruction carries a delay slot. It also flags a compact transfer that sits in the slot of the control transfer issued just before it. Instructions outside the decoded opcodes pass through as plain sequential instructions.

A single major opcode may encode several different branches. The unit tells them apart by comparing the two register-number fields: whether rs is zero, whether rs equals rt, whether rs is numerically at least rt, and whether rt is zero. Within one opcode the offset width, the link rule and the slot rule can all differ. A two-state machine records whether the previous valid instruction was a control transfer. In `SLOT_CLEAR` no transfer is pending. In `SLOT_SHADOW` the previous valid instruction transferred control. The transition *enter_shadow* is taken on any valid control transfer, *leave_shadow* on any other valid instruction, and *hold* on a cycle without a valid instruction.

Top module: `cbr_unit`

## Requirements
- R1: Outputs are registered. `out_valid` is high exactly one clock after a cycle with `in_valid` high. In a cycle where `out_valid` is low, every other output is zero.
- R2: Field positions are opcode [31:26], rs number [25:21] and rt number [20:16]. For opcode 0x06 with rt number non-zero: rs number 0 gives a linking branch on rt≤0, rs equal to rt gives a linking branch on rt≥0, and any other pair gives a non-linking branch on unsigned rs≥rt. Opcode 0x07 does the same with rt>0, rt<0 and unsigned rs<rt.
- R3: For opcode 0x16 with rt number non-zero: rs number 0 gives rt≤0, rs equal to rt gives rt≥0, and otherwise the branch is on signed rs≥rt. Opcode 0x17 uses rt>0, rt<0 and signed rs<rt. None of these link. When the rt number is 0, either opcode raises `out_illegal`.
- R4: For opcode 0x08 with rs number ≥ rt number, the branch is taken when rs+rt overflows as a signed 64-bit sum. Opcode 0x18 in the same case branches when the sum does not overflow. With rs number < rt number, rs number 0 gives a linking branch on rt==0 (0x08) or rt≠0 (0x18). Any other pair branches on rs==rt (0x08) or rs≠rt (0x18), without link.
- R5: Opcode 0x36 with rs number non-zero branches on rs==0, and opcode 0x3E in that case branches on rs≠0. Both use the 21-bit offset in bits [20:0]. With rs number 0, both jump to rt plus the sign-extended bits [15:0], unshifted, and report taken. Only 0x3E links.
- R6: Opcodes 0x32 and 0x3A always branch, using the 26-bit offset in bits [25:0]. Only 0x3A links.
- R7: A taken compact branch goes to PC+4+(sign-extended offset×4). The offset is 16 bits ([15:0]) unless R5 or R6 gives another width. A compact branch that is not taken goes to PC+4.
- R8: A compact link writes PC+4 (`out_link_we` high, `out_link_data` = PC+4) only when the transfer is taken. The link-and-jump form of R5 is always taken. `out_link_data` is zero whenever `out_link_we` is low.
- R9: When the rt number is 0, opcode 0x06 is a delay-slot branch on signed rs≤0 and opcode 0x07 is one on signed rs>0. Either raises `out_delay_slot`. If taken, it goes to PC+4+(sign-extended [15:0]×4). If not taken, it goes to PC+8. It never links.
- R10: `out_forbidden_slot` is high for a compact branch or indirect jump whose preceding valid instruction was any control transfer (legacy, compact or jump). It is low for all other cases, including a legacy branch in that position.
- R11: Any other opcode yields `out_valid` high, next PC = PC+4, and `out_taken`, link, slot and illegal outputs all low.
- R12: An illegal instruction is never taken, never links and has next PC = PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_instr | input | 32 | Instruction word |
| in_pc | input | 64 | Address of the instruction |
| in_rs_val | input | 64 | Value of register rs |
| in_rt_val | input | 64 | Value of register rt |
| out_valid | output | 1 | Result present |
| out_taken | output | 1 | Control transfer taken |
| out_next_pc | output | 64 | Next fetch address |
| out_link_we | output | 1 | Write r31 |
| out_link_data | output | 64 | Value for r31 |
| out_delay_slot | output | 1 | Instruction has a delay slot |
| out_forbidden_slot | output | 1 | Compact transfer sits in a preceding transfer's slot |
| out_illegal | output | 1 | Reserved encoding |

## Verification
Every result is due exactly one rising edge after the cycle in which the instruction was presented. The bench drives each instruction on a falling edge, drops `in_valid` on the next falling edge, and compares all outputs there, half a period after the registering edge. The forbidden-slot flag depends on the previous valid instruction, so each scenario first issues a non-branch instruction to put the machine in `SLOT_CLEAR`. Only the forbidden-slot scenario issues control transfers back to back. One idle cycle after a result, the bench checks that the outputs have returned to zero.

// File: rtl/cbr_pkg.sv
`timescale 1ns/1ps
package cbr_pkg;

    localparam int OPW  = 6;
    localparam int REGW = 5;
    localparam int HIW  = OPW + 2 * REGW;

    localparam logic [OPW-1:0] OP_LEZ_GRP  = 6'h06;
    localparam logic [OPW-1:0] OP_GTZ_GRP  = 6'h07;
    localparam logic [OPW-1:0] OP_OVF_GRP  = 6'h08;
    localparam logic [OPW-1:0] OP_GEC_GRP  = 6'h16;
    localparam logic [OPW-1:0] OP_LTC_GRP  = 6'h17;
    localparam logic [OPW-1:0] OP_NOVF_GRP = 6'h18;
    localparam logic [OPW-1:0] OP_BR26     = 6'h32;
    localparam logic [OPW-1:0] OP_EQZ_JMP  = 6'h36;
    localparam logic [OPW-1:0] OP_BRL26    = 6'h3A;
    localparam logic [OPW-1:0] OP_NEZ_JMPL = 6'h3E;

    typedef enum logic [2:0] {
        K_NONE,
        K_ILLEGAL,
        K_LEGACY,
        K_COMPACT,
        K_JUMP
    } kind_e;

    typedef enum logic [4:0] {
        C_NEVER,
        C_ALWAYS,
        C_RT_LEZ,
        C_RT_GTZ,
        C_RT_GEZ,
        C_RT_LTZ,
        C_GEU,
        C_LTU,
        C_GES,
        C_LTS,
        C_OVF,
        C_NOVF,
        C_RT_EQZ,
        C_RT_NEZ,
        C_EQ,
        C_NE,
        C_RS_EQZ,
        C_RS_NEZ,
        C_RS_LEZ,
        C_RS_GTZ
    } cond_e;

    typedef enum logic [1:0] {
        OFF16,
        OFF21,
        OFF26
    } off_e;

    typedef struct packed {
        kind_e kind;
        cond_e cond;
        off_e  off;
        logic  link;
    } dec_t;

    typedef enum logic {
        SLOT_CLEAR,
        SLOT_SHADOW
    } slot_e;

endpackage

// File: rtl/cbr_decode.sv
`timescale 1ns/1ps
module cbr_decode
    import cbr_pkg::*;
(
    input  logic [HIW-1:0] hi_bits,
    output dec_t           dec
);

    logic [OPW-1:0]  op;
    logic [REGW-1:0] rs_n;
    logic [REGW-1:0] rt_n;
    logic            rs_zero;
    logic            rt_zero;
    logic            same;
    logic            rs_ge_rt;

    assign op       = hi_bits[HIW-1 -: OPW];
    assign rs_n     = hi_bits[2*REGW-1 -: REGW];
    assign rt_n     = hi_bits[REGW-1:0];
    assign rs_zero  = (rs_n == '0);
    assign rt_zero  = (rt_n == '0);
    assign same     = (rs_n == rt_n);
    assign rs_ge_rt = (rs_n >= rt_n);

    always_comb begin
        dec.kind = K_NONE;
        dec.cond = C_NEVER;
        dec.off  = OFF16;
        dec.link = 1'b0;
        unique case (op)
            OP_LEZ_GRP: begin
                if (rt_zero) begin
                    dec.kind = K_LEGACY;
                    dec.cond = C_RS_LEZ;
                end else begin
                    dec.kind = K_COMPACT;
                    if (rs_zero) begin
                        dec.cond = C_RT_LEZ;
                        dec.link = 1'b1;
                    end else if (same) begin
                        dec.cond = C_RT_GEZ;
                        dec.link = 1'b1;
                    end else begin
                        dec.cond = C_GEU;
                    end
                end
            end
            OP_GTZ_GRP: begin
                if (rt_zero) begin
                    dec.kind = K_LEGACY;
                    dec.cond = C_RS_GTZ;
                end else begin
                    dec.kind = K_COMPACT;
                    if (rs_zero) begin
                        dec.cond = C_RT_GTZ;
                        dec.link = 1'b1;
                    end else if (same) begin
                        dec.cond = C_RT_LTZ;
                        dec.link = 1'b1;
                    end else begin
                        dec.cond = C_LTU;
                    end
                end
            end
            OP_GEC_GRP: begin
                if (rt_zero) begin
                    dec.kind = K_ILLEGAL;
                end else begin
                    dec.kind = K_COMPACT;
                    if (rs_zero)   dec.cond = C_RT_LEZ;
                    else if (same) dec.cond = C_RT_GEZ;
                    else           dec.cond = C_GES;
                end
            end
            OP_LTC_GRP: begin
                if (rt_zero) begin
                    dec.kind = K_ILLEGAL;
                end else begin
                    dec.kind = K_COMPACT;
                    if (rs_zero)   dec.cond = C_RT_GTZ;
                    else if (same) dec.cond = C_RT_LTZ;
                    else           dec.cond = C_LTS;
                end
            end
            OP_OVF_GRP: begin
                dec.kind = K_COMPACT;
                if (rs_ge_rt) begin
                    dec.cond = C_OVF;
                end else if (rs_zero) begin
                    dec.cond = C_RT_EQZ;
                    dec.link = 1'b1;
                end else begin
                    dec.cond = C_EQ;
                end
            end
            OP_NOVF_GRP: begin
                dec.kind = K_COMPACT;
                if (rs_ge_rt) begin
                    dec.cond = C_NOVF;
                end else if (rs_zero) begin
                    dec.cond = C_RT_NEZ;
                    dec.link = 1'b1;
                end else begin
                    dec.cond = C_NE;
                end
            end
            OP_EQZ_JMP: begin
                if (rs_zero) begin
                    dec.kind = K_JUMP;
                    dec.cond = C_ALWAYS;
                end else begin
                    dec.kind = K_COMPACT;
                    dec.cond = C_RS_EQZ;
                    dec.off  = OFF21;
                end
            end
            OP_NEZ_JMPL: begin
                if (rs_zero) begin
                    dec.kind = K_JUMP;
                    dec.cond = C_ALWAYS;
                    dec.link = 1'b1;
                end else begin
                    dec.kind = K_COMPACT;
                    dec.cond = C_RS_NEZ;
                    dec.off  = OFF21;
                end
            end
            OP_BR26: begin
                dec.kind = K_COMPACT;
                dec.cond = C_ALWAYS;
                dec.off  = OFF26;
            end
            OP_BRL26: begin
                dec.kind = K_COMPACT;
                dec.cond = C_ALWAYS;
                dec.off  = OFF26;
                dec.link = 1'b1;
            end
            default: begin
                dec.kind = K_NONE;
            end
        endcase
    end

endmodule

// File: rtl/cbr_cond.sv
`timescale 1ns/1ps
module cbr_cond
    import cbr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  cond_e           cond,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic            hit
);

    logic [XLEN-1:0] sum;
    logic            ovf;
    logic            rs_z;
    logic            rt_z;
    logic            rs_neg;
    logic            rt_neg;

    assign sum    = rs_val + rt_val;
    assign ovf    = (rs_val[XLEN-1] == rt_val[XLEN-1]) && (sum[XLEN-1] != rs_val[XLEN-1]);
    assign rs_z   = (rs_val == '0);
    assign rt_z   = (rt_val == '0);
    assign rs_neg = rs_val[XLEN-1];
    assign rt_neg = rt_val[XLEN-1];

    always_comb begin
        unique case (cond)
            C_ALWAYS: hit = 1'b1;
            C_RT_LEZ: hit = rt_neg | rt_z;
            C_RT_GTZ: hit = !rt_neg && !rt_z;
            C_RT_GEZ: hit = !rt_neg;
            C_RT_LTZ: hit = rt_neg;
            C_GEU:    hit = (rs_val >= rt_val);
            C_LTU:    hit = (rs_val < rt_val);
            C_GES:    hit = ($signed(rs_val) >= $signed(rt_val));
            C_LTS:    hit = ($signed(rs_val) < $signed(rt_val));
            C_OVF:    hit = ovf;
            C_NOVF:   hit = !ovf;
            C_RT_EQZ: hit = rt_z;
            C_RT_NEZ: hit = !rt_z;
            C_EQ:     hit = (rs_val == rt_val);
            C_NE:     hit = (rs_val != rt_val);
            C_RS_EQZ: hit = rs_z;
            C_RS_NEZ: hit = !rs_z;
            C_RS_LEZ: hit = rs_neg | rs_z;
            C_RS_GTZ: hit = !rs_neg && !rs_z;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cbr_target.sv
`timescale 1ns/1ps
module cbr_target
    import cbr_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IW   = 32
) (
    input  kind_e           kind,
    input  off_e            off,
    input  logic            hit,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rt_val,
    input  logic [25:0]     imm_bits,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] link_addr
);

    localparam logic [XLEN-1:0] STEP = XLEN'(IW / 8);

    logic [XLEN-1:0] ext16;
    logic [XLEN-1:0] ext21;
    logic [XLEN-1:0] ext26;
    logic [XLEN-1:0] sel_off;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] skip_pc;

    assign ext16   = {{(XLEN-16){imm_bits[15]}}, imm_bits[15:0]};
    assign ext21   = {{(XLEN-21){imm_bits[20]}}, imm_bits[20:0]};
    assign ext26   = {{(XLEN-26){imm_bits[25]}}, imm_bits[25:0]};
    assign seq_pc  = pc + STEP;
    assign skip_pc = seq_pc + STEP;

    always_comb begin
        unique case (off)
            OFF21:   sel_off = ext21;
            OFF26:   sel_off = ext26;
            default: sel_off = ext16;
        endcase
    end

    always_comb begin
        unique case (kind)
            K_LEGACY:  next_pc = hit ? (seq_pc + (ext16 << 2)) : skip_pc;
            K_COMPACT: next_pc = hit ? (seq_pc + (sel_off << 2)) : seq_pc;
            K_JUMP:    next_pc = rt_val + ext16;
            default:   next_pc = seq_pc;
        endcase
    end

    assign link_addr = seq_pc;

endmodule

// File: rtl/cbr_unit.sv
`timescale 1ns/1ps
module cbr_unit
    import cbr_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [IW-1:0]   in_instr,
    input  logic [XLEN-1:0] in_pc,
    input  logic [XLEN-1:0] in_rs_val,
    input  logic [XLEN-1:0] in_rt_val,
    output logic            out_valid,
    output logic            out_taken,
    output logic [XLEN-1:0] out_next_pc,
    output logic            out_link_we,
    output logic [XLEN-1:0] out_link_data,
    output logic            out_delay_slot,
    output logic            out_forbidden_slot,
    output logic            out_illegal
);

    dec_t            dec;
    logic            hit;
    logic            taken;
    logic [XLEN-1:0] next_pc;
    logic [XLEN-1:0] link_addr;
    logic            is_cti;
    logic            is_compact;
    slot_e           slot_q;
    slot_e           slot_d;

    cbr_decode u_decode (
        .hi_bits (in_instr[IW-1 -: HIW]),
        .dec     (dec)
    );

    cbr_cond #(.XLEN(XLEN)) u_cond (
        .cond   (dec.cond),
        .rs_val (in_rs_val),
        .rt_val (in_rt_val),
        .hit    (hit)
    );

    assign taken = hit && (dec.kind != K_NONE) && (dec.kind != K_ILLEGAL);

    cbr_target #(.XLEN(XLEN), .IW(IW)) u_target (
        .kind      (dec.kind),
        .off       (dec.off),
        .hit       (taken),
        .pc        (in_pc),
        .rt_val    (in_rt_val),
        .imm_bits  (in_instr[25:0]),
        .next_pc   (next_pc),
        .link_addr (link_addr)
    );

    assign is_cti     = (dec.kind == K_LEGACY) || (dec.kind == K_COMPACT) || (dec.kind == K_JUMP);
    assign is_compact = (dec.kind == K_COMPACT) || (dec.kind == K_JUMP);

    // slot state register
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= SLOT_CLEAR;
        else        slot_q <= slot_d;
    end

    // slot transitions: enter_shadow, leave_shadow, hold
    always_comb begin
        slot_d = slot_q;
        unique case (slot_q)
            SLOT_CLEAR: begin
                if (in_valid && is_cti) slot_d = SLOT_SHADOW;
            end
            SLOT_SHADOW: begin
                if (in_valid && !is_cti) slot_d = SLOT_CLEAR;
            end
            default: slot_d = SLOT_CLEAR;
        endcase
    end

    // registered result
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid          <= 1'b0;
            out_taken          <= 1'b0;
            out_next_pc        <= '0;
            out_link_we        <= 1'b0;
            out_link_data      <= '0;
            out_delay_slot     <= 1'b0;
            out_forbidden_slot <= 1'b0;
            out_illegal        <= 1'b0;
        end else begin
            out_valid          <= 1'b1;
            out_taken          <= taken;
            out_next_pc        <= next_pc;
            out_link_we        <= dec.link && taken;
            out_link_data      <= (dec.link && taken) ? link_addr : '0;
            out_delay_slot     <= (dec.kind == K_LEGACY);
            out_forbidden_slot <= is_compact && (slot_q == SLOT_SHADOW);
            out_illegal        <= (dec.kind == K_ILLEGAL);
        end
    end

endmodule

// File: rtl/cbr_unit_checker.sv
`timescale 1ns/1ps
module cbr_unit_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] in_pc,
    input logic            out_valid,
    input logic            out_taken,
    input logic [XLEN-1:0] out_next_pc,
    input logic            out_link_we,
    input logic [XLEN-1:0] out_link_data,
    input logic            out_delay_slot,
    input logic            out_forbidden_slot,
    input logic            out_illegal
);

    a_r1_valid_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_taken && !out_link_we && !out_delay_slot &&
                        !out_forbidden_slot && !out_illegal && out_next_pc == '0));

    a_r8_link_needs_taken: assert property (@(posedge clk) disable iff (!rst_n)
        out_link_we |-> out_taken);

    a_r8_link_value: assert property (@(posedge clk) disable iff (!rst_n)
        out_link_we |-> (out_link_data == $past(in_pc) + XLEN'(4)));

    a_r7_compact_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_taken && !out_delay_slot) |-> (out_next_pc == $past(in_pc) + XLEN'(4)));

    a_r9_legacy_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (out_delay_slot && !out_taken) |-> (out_next_pc == $past(in_pc) + XLEN'(8)));

    a_r9_legacy_no_link: assert property (@(posedge clk) disable iff (!rst_n)
        out_delay_slot |-> !out_link_we);

    a_r10_forbidden_compact_only: assert property (@(posedge clk) disable iff (!rst_n)
        out_forbidden_slot |-> (!out_delay_slot && !out_illegal));

    a_r12_illegal_inert: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (!out_taken && !out_link_we && !out_delay_slot));

endmodule

bind cbr_unit cbr_unit_checker #(.XLEN(XLEN)) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .in_valid           (in_valid),
    .in_pc              (in_pc),
    .out_valid          (out_valid),
    .out_taken          (out_taken),
    .out_next_pc        (out_next_pc),
    .out_link_we        (out_link_we),
    .out_link_data      (out_link_data),
    .out_delay_slot     (out_delay_slot),
    .out_forbidden_slot (out_forbidden_slot),
    .out_illegal        (out_illegal)
);

// File: tb/cbr_unit_tb.sv
`timescale 1ns/1ps
module cbr_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [63:0] in_pc = '0;
    logic [63:0] in_rs_val = '0;
    logic [63:0] in_rt_val = '0;
    logic        out_valid;
    logic        out_taken;
    logic [63:0] out_next_pc;
    logic        out_link_we;
    logic [63:0] out_link_data;
    logic        out_delay_slot;
    logic        out_forbidden_slot;
    logic        out_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [63:0] P  = 64'h0000_0000_0000_1000;
    localparam logic [63:0] M1 = 64'hFFFF_FFFF_FFFF_FFFF;

    always #2.5 clk = ~clk;

    cbr_unit u_dut (
        .clk                (clk),
        .rst_n              (rst_n),
        .in_valid           (in_valid),
        .in_instr           (in_instr),
        .in_pc              (in_pc),
        .in_rs_val          (in_rs_val),
        .in_rt_val          (in_rt_val),
        .out_valid          (out_valid),
        .out_taken          (out_taken),
        .out_next_pc        (out_next_pc),
        .out_link_we        (out_link_we),
        .out_link_data      (out_link_data),
        .out_delay_slot     (out_delay_slot),
        .out_forbidden_slot (out_forbidden_slot),
        .out_illegal        (out_illegal)
    );

    function automatic logic [31:0] mk_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] mk_21(logic [5:0] op, logic [4:0] rs, logic [20:0] off);
        return {op, rs, off};
    endfunction

    function automatic logic [31:0] mk_26(logic [5:0] op, logic [25:0] off);
        return {op, off};
    endfunction

    function automatic logic [63:0] dest(logic [63:0] pc, logic signed [63:0] off);
        return pc + 64'd4 + (off * 4);
    endfunction

    task automatic check(string tag, logic v, logic t, logic [63:0] np, logic lwe,
                         logic [63:0] ld, logic ds, logic fs, logic il);
        checks++;
        if ({out_valid, out_taken, out_next_pc, out_link_we, out_link_data,
             out_delay_slot, out_forbidden_slot, out_illegal} !==
            {v, t, np, lwe, ld, ds, fs, il}) begin
            errors++;
            $display("FAIL %s: actual v=%0b t=%0b np=%h lwe=%0b ld=%h ds=%0b fs=%0b il=%0b expected v=%0b t=%0b np=%h lwe=%0b ld=%h ds=%0b fs=%0b il=%0b",
                     tag, out_valid, out_taken, out_next_pc, out_link_we, out_link_data,
                     out_delay_slot, out_forbidden_slot, out_illegal, v, t, np, lwe, ld, ds, fs, il);
        end
    endtask

    task automatic issue(logic [31:0] ins, logic [63:0] pc, logic [63:0] rs, logic [63:0] rt);
        @(negedge clk);
        in_valid  = 1'b1;
        in_instr  = ins;
        in_pc     = pc;
        in_rs_val = rs;
        in_rt_val = rt;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    // clear the slot machine with a plain instruction, then issue
    task automatic run(logic [31:0] ins, logic [63:0] pc, logic [63:0] rs, logic [63:0] rt);
        issue(32'h0000_0000, 64'h0, 64'h0, 64'h0);
        issue(ins, pc, rs, rt);
    endtask

    task automatic t_reset();
        check("R1 reset state", 0, 0, 64'h0, 0, 64'h0, 0, 0, 0);
    endtask

    task automatic t_idle();
        run(mk_26(6'h32, 26'h10), P, 0, 0);
        @(negedge clk);
        check("R1 idle after result", 0, 0, 64'h0, 0, 64'h0, 0, 0, 0);
    endtask

    task automatic t_pop06_07();
        run(mk_i(6'h06, 5'd0, 5'd5, 16'h0010), P, 0, 64'd0);
        check("R2 rt<=0 link taken", 1, 1, dest(P, 16), 1, P + 4, 0, 0, 0);
        run(mk_i(6'h06, 5'd0, 5'd5, 16'h0010), P, 0, 64'd1);
        check("R2 rt<=0 not taken", 1, 0, P + 4, 0, 64'h0, 0, 0, 0);
        run(mk_i(6'h06, 5'd5, 5'd5, 16'h0010), P, M1, M1);
        check("R2 rt>=0 not taken", 1, 0, P + 4, 0, 64'h0, 0, 0, 0);
        run(mk_i(6'h06, 5'd3, 5'd4, 16'hFFFE), P, M1, 64'd1);
        check("R2 unsigned ge taken no link", 1, 1, dest(P, -2), 0, 64'h0, 0, 0, 0);
        run(mk_i(6'h07, 5'd5, 5'd5, 16'h0004), P, M1, M1);
        check("R2 rt<0 link taken", 1, 1, dest(P, 4), 1, P + 4, 0, 0, 0);
        run(mk_i(6'h07, 5'd3, 5'd4, 16'h0004), P, M1, 64'd1);
        check("R2 unsigned lt not taken", 1, 0, P + 4, 0, 64'h0, 0, 0, 0);
    endtask

    task automatic t_legacy();
        run(mk_i(6'h06, 5'd3, 5'd0, 16'h0020), P, 64'd0, 0);
        check("R9 rs<=0 taken", 1, 1, dest(P, 32), 0, 64'h0, 1, 0, 0);
        run(mk_i(6'h07, 5'd3, 5'd0, 16'h0020), P, 64'd0, 0);
        check("R9 rs>0 not taken", 1, 0, P + 8, 0, 64'h0, 1, 0, 0);
        run(mk_i(6'h07, 5'd3, 5'd0, 16'hFFF0), P, 64'd9, 0);
        check("R9 rs>0 taken back", 1, 1, dest(P, -16), 0, 64'h0, 1, 0, 0);
    endtask

    task automatic t_pop26_27();
        run(mk_i(6'h16, 5'd0, 5'd2, 16'h0008), P, 0, 64'hFFFF_FFFF_FFFF_FFFB);
        check("R3 rt<=0 taken", 1, 1, dest(P, 8), 0, 64'h0, 0, 0, 0);
        run(mk_i(6'h16, 5'd1, 5'd2, 16'h0008), P, M1, 64'd1);
        check("R3 signed ge not taken", 1, 0, P + 4, 0, 64'h0, 0, 0, 0);
        run(mk_i(6'h17, 5'd1, 5'd2, 16'h0008), P, 64'hFFFF_FFFF_FFFF_FFFD, 64'd2);
        check("R3 signed lt taken", 1, 1, dest(P, 8), 0, 64'h0, 0, 0, 0);
        run(mk_i(6'h17, 5'd2, 5'd2, 16'h0008), P, 64'd4, 64'd4);
        check("R3 rt<0 not taken", 1, 0, P + 4, 0, 64'h0, 0, 0, 0);
        run(mk_i(6'h16, 5'd4, 5'd0, 16'h0008), P, 0, 0);
        check("R3 R12 illegal rt=0", 1, 0, P + 4, 0, 64'h0, 0, 0, 1);
    endtask

    task automatic t_pop10_30();
        run(mk_i(6'h08, 5'd5, 5'd3, 16'h0002), P, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
        check("R4 overflow taken", 1, 1, dest(P, 2), 0, 64'h0, 0, 0, 0);
        run(mk_i(6'h08, 5'd5, 5'd3, 16'h0002), P, 64'h8000_0000_0000_0000, M1);
        check("R4 negative overflow taken", 1, 1, dest(P, 2), 0, 64'h0, 0, 0, 0);
        run(mk_i(6'h18, 5'd5, 5'd3, 16'h0002), P, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
        check("R4 no-overflow not taken", 1, 0, P + 4, 0, 64'h0, 0, 0, 0);
        run(mk_i(6'h18, 5'd5, 5'd3, 16'h0002), P, 64'd1, 64'd1);
        check("R4 no-overflow taken", 1, 1, dest(P, 2), 0, 64'h0, 0, 0, 0);
        run(mk_i(6'h08, 5'd0, 5'd3, 16'h0002), P, 64'd7, 64'd0);
        check("R4 rt==0 link taken", 1, 1, dest(P, 2), 1, P + 4, 0, 0, 0);
        run(mk_i(6'h18, 5'd0, 5'd3, 16'h0002), P, 64'd7, 64'd0);
        check("R4 R8 rt!=0 not taken no link", 1, 0, P + 4, 0, 64'h0, 0, 0, 0);
        run(mk_i(6'h08, 5'd2, 5'd3, 16'h0002), P, 64'd7, 64'd7);
        check("R4 rs==rt taken", 1, 1, dest(P, 2), 0, 64'h0, 0, 0, 0);
        run(mk_i(6'h18, 5'd2, 5'd3, 16'h0002), P, 64'd7, 64'd7);
        check("R4 rs!=rt not taken", 1, 0, P + 4, 0, 64'h0, 0, 0, 0);
    endtask

    task automatic t_pop66_76();
        run(mk_21(6'h36, 5'd4, 21'h1FFFFF), P, 64'd0, 0);
        check("R5 R7 eqz 21-bit taken", 1, 1, dest(P, -1), 0, 64'h0, 0, 0, 0);
        run(mk_21(6'h36, 5'd4, 21'h100000), P, 64'd0, 0);
        check("R5 eqz 21-bit sign bit", 1, 1, dest(P, -1048576), 0, 64'h0, 0, 0, 0);
        run(mk_21(6'h3E, 5'd4, 21'h000040), P, 64'd0, 0);
        check("R5 nez not taken", 1, 0, P + 4, 0, 64'h0, 0, 0, 0);
        run(mk_i(6'h36, 5'd0, 5'd6, 16'hFFF0), P, 0, 64'h2000);
        check("R5 indirect jump", 1, 1, 64'h1FF0, 0, 64'h0, 0, 0, 0);
        run(mk_i(6'h3E, 5'd0, 5'd6, 16'h0013), P, 0, 64'h2000);
        check("R5 R8 indirect jump link", 1, 1, 64'h2013, 1, P + 4, 0, 0, 0);
    endtask

    task automatic t_bc_balc();
        run(mk_26(6'h32, 26'h0000100), P, 0, 0);
        check("R6 R7 26-bit branch", 1, 1, dest(P, 256), 0, 64'h0, 0, 0, 0);
        run(mk_26(6'h3A, 26'h3FFFFFC), P, 0, 0);
        check("R6 R8 26-bit link back", 1, 1, dest(P, -4), 1, P + 4, 0, 0, 0);
        run(mk_26(6'h3A, 26'h2000000), P, 0, 0);
        check("R6 26-bit sign bit", 1, 1, dest(P, -33554432), 1, P + 4, 0, 0, 0);
    endtask

    task automatic t_other();
        run(mk_i(6'h23, 5'd1, 5'd0, 16'h0010), P, 64'd0, 64'd0);
        check("R11 other opcode", 1, 0, P + 4, 0, 64'h0, 0, 0, 0);
        run(mk_i(6'h17, 5'd1, 5'd0, 16'h0010), P, 64'd0, 64'd5);
        check("R12 illegal inert", 1, 0, P + 4, 0, 64'h0, 0, 0, 1);
    endtask

    task automatic t_forbidden();
        run(mk_26(6'h32, 26'h10), P, 0, 0);
        issue(mk_21(6'h36, 5'd4, 21'h8), P + 4, 64'd0, 0);
        check("R10 compact in shadow", 1, 1, dest(P + 4, 8), 0, 64'h0, 0, 1, 0);
        issue(mk_i(6'h06, 5'd3, 5'd0, 16'h8), P + 8, 64'd1, 0);
        check("R10 legacy in shadow not flagged", 1, 0, P + 16, 0, 64'h0, 1, 0, 0);
        issue(mk_i(6'h3E, 5'd0, 5'd6, 16'h0), P + 12, 0, 64'h3000);
        check("R10 jump after legacy flagged", 1, 1, 64'h3000, 1, P + 16, 0, 1, 0);
        issue(mk_i(6'h23, 5'd0, 5'd0, 16'h0), P + 16, 0, 0);
        check("R10 R11 plain in shadow", 1, 0, P + 20, 0, 64'h0, 0, 0, 0);
        issue(mk_26(6'h32, 26'h1), P + 20, 0, 0);
        check("R10 compact after plain", 1, 1, dest(P + 20, 1), 0, 64'h0, 0, 0, 0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_pop06_07();
        t_legacy();
        t_pop26_27();
        t_pop10_30();
        t_pop66_76();
        t_bc_balc();
        t_other();
        t_forbidden();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule